// File: doc/BRIEF.md
# Byte-Oriented SPI Master/Slave Controller

This block moves one byte at a time over a full-duplex serial link and can act as either end of the link. As a master it makes the serial clock from the system clock through a divider and shifts out a byte as soon as that byte is written. As a slave it samples the incoming serial clock, data and select lines with the system clock and shifts only while select is held low. The master never drives a select line; the surrounding logic owns it.

There is one shift register for both directions. It takes the transmit byte on a write. At the end of each byte the shifted-in value is copied to a receive buffer, so receive is double-buffered and transmit is single-buffered. One clock mode is fixed: the serial clock idles low, data is sampled on the rising edge and changed on the falling edge.

A transfer-complete flag and a write-collision flag report progress. An interrupt request combines the complete flag with an enable. Both flags clear when the receive buffer is read after a status read.

Top module: `spi_byte_ctrl`

## Requirements
- R1: In master mode, a data write accepted while idle starts a transfer. The transfer makes exactly eight rising edges on `sck_o`, then `sck_o` stays low and `done_o` sets.
- R2: `sck_o` is low while idle. The master presents the first bit on `mosi_o` as soon as the byte is loaded, changes `mosi_o` only after a falling edge, and samples `miso_i` on the rising edge.
- R3: The master clock period in system cycles is 4, 16, 64 or 128 for `rate_i` = 0, 1, 2 or 3. With `dbl_i` = 1 it is half of that (2, 8, 32 or 64). This gives seven distinct rates.
- R4: `lsb_first_i` = 1 sends and receives bit 0 first; `lsb_first_i` = 0 sends and receives bit 7 first.
- R5: In slave mode with `ss_n_i` high, `miso_oe_o` is low and edges on `sck_i` shift nothing: `done_o` stays low and `rdata_o` keeps its value.
- R6: In slave mode with `ss_n_i` low, the block drives `miso_oe_o` high and shifts a byte on an `sck_i` that runs at no more than a quarter of the system clock. After each byte the shift register holds the received byte, and that byte is what the next frame sends.
- R7: A data write during an active transfer sets `wcol_o`, and the byte being sent is not changed.
- R8: `rdata_o` holds the last completed byte until the next byte completes. An unread byte is then overwritten.
- R9: `irq_o` is high exactly when `done_o` and `irq_en_i` are both high.
- R10: A `rd_data_i` pulse that follows a `rd_stat_i` pulse (given while a flag was set) clears `done_o` and `wcol_o`. A `rd_data_i` pulse without that status read leaves them set.
- R11: After reset, `done_o`, `wcol_o`, `irq_o`, `sck_o`, `miso_oe_o` and `rdata_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| master_i | input | 1 | 1 = master, 0 = slave |
| lsb_first_i | input | 1 | Bit order select |
| rate_i | input | 2 | Master clock divider select |
| dbl_i | input | 1 | Halves the divide ratio |
| irq_en_i | input | 1 | Interrupt enable |
| wr_i | input | 1 | Data write strobe |
| wdata_i | input | DATA_W | Byte to transmit |
| rd_stat_i | input | 1 | Status read strobe |
| rd_data_i | input | 1 | Receive buffer read strobe |
| rdata_o | output | DATA_W | Receive buffer |
| done_o | output | 1 | Transfer-complete flag |
| wcol_o | output | 1 | Write-collision flag |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| sck_i | input | 1 | Slave serial clock in |
| ss_n_i | input | 1 | Slave select, active low |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe_o | output | 1 | Slave data out enable |

## Verification
The divider's range check assumes that `rate_i` and `dbl_i` do not change while a master transfer runs. The master and mode inputs are likewise taken to be steady during a byte. The bench changes these inputs only between transfers, with the block idle. The slave checks assume `sck_i` half periods of at least two system cycles. The stimulus uses four cycles per half period, so the synchronised clock, data and select lines stay aligned. It also raises and lowers `ss_n_i` only while `sck_i` is low.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

   typedef enum logic {
      ORDER_MSB = 1'b0,
      ORDER_LSB = 1'b1
   } order_e;

   // half of the master clock period, in system cycles
   function automatic logic [6:0] half_period(input logic [1:0] rate, input logic dbl);
      logic [7:0] ratio;
      ratio = (rate == 2'd3) ? 8'd128 : (8'd4 << {rate, 1'b0});
      if (dbl) ratio = ratio >> 1;
      return ratio[7:1];
   endfunction

endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
   parameter int STAGES = 2,
   parameter bit INIT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial assert (STAGES >= 2) else $error("spi_sync_edge: STAGES must be at least 2");

   logic [STAGES-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{INIT}};
      else        pipe <= {pipe[STAGES-2:0], d_i};
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_clk_div.sv
module spi_clk_div
   import spi_byte_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic [1:0] rate_i,
   input  logic       dbl_i,
   output logic       tick_o
);
   initial assert (CNT_W >= 7) else $error("spi_clk_div: CNT_W too small for the slowest rate");

   logic [CNT_W-1:0] cnt;
   logic [6:0]       half;

   assign half   = half_period(rate_i, dbl_i);
   assign tick_o = run_i && (cnt == CNT_W'(half - 7'd1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (!run_i || tick_o)  cnt <= '0;
      else                        cnt <= cnt + 1'b1;
   end

   // R3
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !run_i)
      cnt < CNT_W'(half));
endmodule

// File: rtl/spi_byte_ctrl.sv
module spi_byte_ctrl
   import spi_byte_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_CNT_W   = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              master_i,
   input  logic              lsb_first_i,
   input  logic [1:0]        rate_i,
   input  logic              dbl_i,
   input  logic              irq_en_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rd_stat_i,
   input  logic              rd_data_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              done_o,
   output logic              wcol_o,
   output logic              irq_o,
   output logic              sck_o,
   output logic              mosi_o,
   input  logic              miso_i,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              mosi_i,
   output logic              miso_o,
   output logic              miso_oe_o
);
   localparam int BC_W = $clog2(DATA_W + 1);

   initial assert (DATA_W >= 2) else $error("spi_byte_ctrl: DATA_W must be at least 2");

   logic              is_master, is_slave, ss_act;
   logic              sck_s, ss_s, mosi_s, sck_prev;
   logic              m_busy, sck_q, tick;
   logic              samp_ev, shift_ev, final_ev, busy, wr_ok, wr_col;
   logic              smp, in_bit, out_bit;
   logic [BC_W-1:0]   bitcnt;
   logic [DATA_W-1:0] sh, sh_next, rx_q;
   logic              done_q, wcol_q, stat_armed;

   assign is_master = en_i && master_i;
   assign is_slave  = en_i && !master_i;

   spi_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d_i(sck_i), .q_o(sck_s));
   spi_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_ss (
      .clk(clk), .rst_n(rst_n), .d_i(ss_n_i), .q_o(ss_s));
   spi_sync_edge #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_mosi (
      .clk(clk), .rst_n(rst_n), .d_i(mosi_i), .q_o(mosi_s));

   spi_clk_div #(.CNT_W(DIV_CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .run_i(m_busy), .rate_i(rate_i), .dbl_i(dbl_i), .tick_o(tick));

   assign ss_act   = is_slave && !ss_s;
   assign samp_ev  = (m_busy && tick && !sck_q) || (ss_act && sck_s && !sck_prev);
   assign shift_ev = (m_busy && tick &&  sck_q) || (ss_act && !sck_s && sck_prev);
   assign final_ev = shift_ev && (bitcnt == BC_W'(DATA_W));
   assign busy     = m_busy || (ss_act && (bitcnt != '0));
   assign wr_ok    = wr_i && en_i && !busy;
   assign wr_col   = wr_i && en_i && busy;
   assign in_bit   = m_busy ? miso_i : mosi_s;

   // bit order picks the shift direction and the serial bit
   always_comb begin
      if (order_e'(lsb_first_i) == ORDER_LSB) begin
         sh_next = {smp, sh[DATA_W-1:1]};
         out_bit = sh[0];
      end else begin
         sh_next = {sh[DATA_W-2:0], smp};
         out_bit = sh[DATA_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_prev <= 1'b0;
         m_busy   <= 1'b0;
         sck_q    <= 1'b0;
         bitcnt   <= '0;
         smp      <= 1'b0;
         sh       <= '0;
         rx_q     <= '0;
      end else begin
         sck_prev <= sck_s;

         if (!is_master || final_ev) m_busy <= 1'b0;
         else if (wr_ok)             m_busy <= 1'b1;

         if (!m_busy)   sck_q <= 1'b0;
         else if (tick) sck_q <= !sck_q;

         if (!ss_act && !m_busy) bitcnt <= '0;
         else if (final_ev)      bitcnt <= '0;
         else if (samp_ev)       bitcnt <= bitcnt + 1'b1;

         if (samp_ev) smp <= in_bit;

         if (wr_ok)         sh <= wdata_i;
         else if (shift_ev) sh <= sh_next;

         if (final_ev) rx_q <= sh_next;
      end
   end

   // flags: cleared by a buffer read that follows a status read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q     <= 1'b0;
         wcol_q     <= 1'b0;
         stat_armed <= 1'b0;
      end else begin
         if (rd_data_i)                         stat_armed <= 1'b0;
         else if (rd_stat_i && (done_q || wcol_q)) stat_armed <= 1'b1;

         if (final_ev)                      done_q <= 1'b1;
         else if (rd_data_i && stat_armed)  done_q <= 1'b0;

         if (wr_col)                        wcol_q <= 1'b1;
         else if (rd_data_i && stat_armed)  wcol_q <= 1'b0;
      end
   end

   assign rdata_o   = rx_q;
   assign done_o    = done_q;
   assign wcol_o    = wcol_q;
   assign irq_o     = done_q && irq_en_i;
   assign sck_o     = sck_q;
   assign mosi_o    = m_busy ? out_bit : 1'b0;
   assign miso_o    = out_bit;
   assign miso_oe_o = ss_act;

   // R1
   bitcnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt <= BC_W'(DATA_W));

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !m_busy |=> !sck_q);

   // R5
   slave_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_slave && ss_s) |=> (bitcnt == '0));

   // R7
   wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && en_i && busy) |=> wcol_q);

   // R10
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_i && !stat_armed && done_q) |=> done_q);
endmodule

// File: tb/spi_byte_ctrl_test.sv
module spi_byte_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_i = 1'b0, master_i = 1'b0, lsb_first_i = 1'b0, dbl_i = 1'b0, irq_en_i = 1'b0;
   logic [1:0] rate_i = 2'd0;
   logic       wr_i = 1'b0, rd_stat_i = 1'b0, rd_data_i = 1'b0;
   logic [7:0] wdata_i = 8'h00;
   logic [7:0] rdata_o;
   logic       done_o, wcol_o, irq_o, sck_o, mosi_o, miso_o, miso_oe_o;
   logic       miso_i = 1'b0, sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;

   int   n_checks = 0;
   int   n_errors = 0;
   bit   finished = 1'b0;
   logic [7:0] exp_q[$];
   logic done_d = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_byte_ctrl uut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .master_i(master_i), .lsb_first_i(lsb_first_i),
      .rate_i(rate_i), .dbl_i(dbl_i), .irq_en_i(irq_en_i), .wr_i(wr_i), .wdata_i(wdata_i),
      .rd_stat_i(rd_stat_i), .rd_data_i(rd_data_i), .rdata_o(rdata_o), .done_o(done_o),
      .wcol_o(wcol_o), .irq_o(irq_o), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
      .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe_o(miso_oe_o));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: each new completion pops one expected byte
   always @(negedge clk) begin
      logic [7:0] e_v;
      if (rst_n && done_o && !done_d) begin
         if (exp_q.size() == 0) begin
            n_checks++; n_errors++;
            $display("FAIL R8: unexpected completion, actual 0x%0h expected none", rdata_o);
         end else begin
            e_v = exp_q.pop_front();
            check(rdata_o == e_v, "R8 received byte", rdata_o, e_v);
         end
      end
      done_d <= done_o;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_byte(input logic [7:0] b);
      @(negedge clk); wr_i = 1'b1; wdata_i = b;
      @(negedge clk); wr_i = 1'b0;
   endtask

   task automatic clear_flags();
      @(negedge clk); rd_stat_i = 1'b1;
      @(negedge clk); rd_stat_i = 1'b0; rd_data_i = 1'b1;
      @(negedge clk); rd_data_i = 1'b0;
   endtask

   task automatic wait_done(input int lim);
      for (int i = 0; i < lim && !done_o; i++) @(negedge clk);
   endtask

   function automatic int bit_idx(input int i, input bit lsb);
      return lsb ? i : 7 - i;
   endfunction

   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] sv, input bit lsb,
                              input logic [1:0] rate, input bit dbl, input int ratio, input bit collide);
      logic [7:0] got;
      time t0, t1;
      int rises, highs;
      @(negedge clk);
      master_i = 1'b1; lsb_first_i = lsb; rate_i = rate; dbl_i = dbl;
      miso_i = sv[bit_idx(0, lsb)];
      exp_q.push_back(sv);
      got = 8'h00; rises = 0; t0 = 0; t1 = 0;
      fork
         write_byte(tx);
         begin
            for (int i = 0; i < 8; i++) begin
               @(posedge sck_o);
               rises++;
               if (i == 0) t0 = $time;
               if (i == 1) t1 = $time;
               got[bit_idx(i, lsb)] = mosi_o;
               if (collide && i == 2) begin
                  fork write_byte(8'hFF); join_none
               end
               @(negedge sck_o); #1;
               if (i < 7) miso_i = sv[bit_idx(i + 1, lsb)];
            end
         end
      join
      wait_done(ratio * 4 + 50);
      check(done_o == 1'b1, "R1 done after eight bits", done_o, 1);
      check(got == tx, "R2 R4 bits sent on mosi", got, tx);
      check(rises == 8, "R1 rising edge count", rises, 8);
      check((t1 - t0) == time'(ratio * CLK_PERIOD), "R3 clock period", int'(t1 - t0), ratio * CLK_PERIOD);
      highs = 0;
      for (int i = 0; i < 2 * ratio + 4; i++) begin
         @(negedge clk);
         if (sck_o) highs++;
      end
      check(highs == 0, "R1 R2 sck idle low after byte", highs, 0);
   endtask

   task automatic slave_frame(input logic [7:0] mv, input bit lsb, output logic [7:0] got, output bit oe_ok);
      got = 8'h00; oe_ok = 1'b1;
      @(negedge clk); lsb_first_i = lsb; ss_n_i = 1'b0;
      tick(8);
      for (int i = 0; i < 8; i++) begin
         mosi_i = mv[bit_idx(i, lsb)];
         tick(4);
         sck_i = 1'b1;
         got[bit_idx(i, lsb)] = miso_o;
         if (!miso_oe_o) oe_ok = 1'b0;
         tick(4);
         sck_i = 1'b0;
      end
      tick(8);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++; n_errors++;
         $display("FAIL R1 watchdog: actual 0 expected 1 (run completion)");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] got, got2, held;
      bit oe_ok;
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R11 reset state
      check(done_o == 0,    "R11 done after reset", done_o, 0);
      check(wcol_o == 0,    "R11 wcol after reset", wcol_o, 0);
      check(irq_o == 0,     "R11 irq after reset", irq_o, 0);
      check(sck_o == 0,     "R11 sck after reset", sck_o, 0);
      check(miso_oe_o == 0, "R11 miso_oe after reset", miso_oe_o, 0);
      check(rdata_o == 0,   "R11 rdata after reset", rdata_o, 0);

      en_i = 1'b1; irq_en_i = 1'b1;
      master_xfer(8'hA5, 8'h3C, 1'b0, 2'd0, 1'b0, 4, 1'b0);
      check(irq_o == 1, "R9 irq with enable", irq_o, 1);

      // R10: buffer read without status read keeps the flag
      @(negedge clk); rd_data_i = 1'b1;
      @(negedge clk); rd_data_i = 1'b0;
      tick(1);
      check(done_o == 1, "R10 flag kept without status read", done_o, 1);
      clear_flags(); tick(1);
      check(done_o == 0, "R10 flag cleared", done_o, 0);
      check(irq_o == 0,  "R9 irq drops with flag", irq_o, 0);

      irq_en_i = 1'b0;
      master_xfer(8'h13, 8'hC8, 1'b1, 2'd1, 1'b1, 8, 1'b0);
      check(irq_o == 0, "R9 irq masked", irq_o, 0);
      clear_flags();
      master_xfer(8'h5A, 8'h96, 1'b0, 2'd3, 1'b0, 128, 1'b0);
      clear_flags();
      master_xfer(8'hE7, 8'h21, 1'b1, 2'd0, 1'b1, 2, 1'b0);
      clear_flags();

      // R7 collision during transfer
      master_xfer(8'h4B, 8'hD2, 1'b0, 2'd2, 1'b0, 64, 1'b1);
      check(wcol_o == 1, "R7 collision flag", wcol_o, 1);
      clear_flags(); tick(1);
      check(wcol_o == 0, "R10 collision flag cleared", wcol_o, 0);

      // R6 slave transfer
      @(negedge clk); master_i = 1'b0;
      write_byte(8'h6D);
      exp_q.push_back(8'hB2);
      slave_frame(8'hB2, 1'b0, got, oe_ok);
      check(got == 8'h6D, "R6 slave sent byte", got, 8'h6D);
      check(oe_ok == 1'b1, "R6 miso driven with select low", oe_ok, 1);
      ss_n_i = 1'b1; tick(6);
      check(miso_oe_o == 0, "R5 miso released with select high", miso_oe_o, 0);
      clear_flags();

      // R5 clock ignored while deselected
      held = rdata_o;
      for (int i = 0; i < 8; i++) begin
         mosi_i = i[0]; tick(4); sck_i = 1'b1; tick(4); sck_i = 1'b0;
      end
      tick(8);
      check(done_o == 0, "R5 no completion while deselected", done_o, 0);
      check(rdata_o == held, "R5 buffer unchanged while deselected", rdata_o, held);

      // R8 overrun: second byte replaces unread first byte
      write_byte(8'h0F);
      exp_q.push_back(8'h11);
      slave_frame(8'h11, 1'b1, got, oe_ok);
      ss_n_i = 1'b1; tick(6);
      check(got == 8'h0F, "R4 R6 slave lsb-first send", got, 8'h0F);
      check(rdata_o == 8'h11, "R8 first byte held", rdata_o, 8'h11);
      slave_frame(8'h22, 1'b1, got2, oe_ok);
      ss_n_i = 1'b1; tick(6);
      check(got2 == 8'h11, "R6 received byte sent back", got2, 8'h11);
      check(rdata_o == 8'h22, "R8 unread byte overwritten", rdata_o, 8'h22);
      check(done_o == 1, "R8 flag still set", done_o, 1);
      clear_flags(); tick(2);
      check(exp_q.size() == 0, "R8 all expected bytes seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule